// File: doc/BRIEF.md
# Predicated Result Commit Gate

This block sits between the execution units and the register writeback path. It keeps a bank of one-bit predicate flags. For every result that comes off a functional unit, it decides whether that result is written back or thrown away. The decision uses the predicate index carried with the result. The compiler can schedule operations from both arms of a conditional side by side. Each operation is tagged with the predicate for its own arm, and only results whose predicate turns out true reach the register file.

An operation may be started before the compare that produces its predicate has finished. Each flag therefore has a pending bit. The pending bit is raised when a predicate-producing operation issues and dropped when that operation writes its value. A result that arrives while its predicate is pending is parked in a small in-order buffer. It is released once the predicate is known, and then written back if the predicate is 1 or dropped if it is 0. When the buffer is full the block deasserts its ready output and the functional units must hold their result. Flag 0 always reads as 1 and is never pending, so an index of 0 means "unconditional".

Top module: `pred_commit_gate`

## Requirements
- R1: After reset no writeback or discard is signalled, `res_ready` is 1, and flags 1..63 read as 0 and not pending, so a result naming flag 5 is discarded.
- R2: Flag 0 always reads as 1 and is never pending. Writes to it and pending-issues on it have no effect, so a result with index 0 is committed one cycle after acceptance.
- R3: A result accepted while its flag is known to be 1 (and nothing is parked) appears on `wb_valid`/`wb_dest`/`wb_data` in the cycle after the accepting clock edge, for exactly one cycle.
- R4: A result accepted while its flag is known to be 0 appears on `disc_valid`/`disc_dest` in the cycle after acceptance, and it never produces a writeback. Writeback and discard are never signalled together.
- R5: A pending-issue on index i at a clock edge makes flag i pending from the next cycle on. A result naming a pending flag produces no output while the flag stays pending.
- R6: A predicate write clears pending and sets the value. A parked result at the head of the buffer is decided at the edge where its flag is written, and its outcome appears in the following cycle.
- R7: When a predicate write and a result that names the same flag arrive in the same cycle, the value being written decides the outcome.
- R8: Parked results leave in arrival order, at most one outcome per cycle. A later result whose flag is already known waits behind older parked ones.
- R9: The buffer holds 4 results. With 4 parked, `res_ready` is 0 and a result offered then is not taken and never produces an outcome.
- R10: Results from both arms of a branch may be parked together. After the arms' flags are written 1 and 0, only the arm whose flag is 1 is committed and the other is discarded.
- R11: If both write ports name the same flag in one cycle, port 1 wins. If a pending-issue and a write name the same flag in one cycle, the flag takes the written value and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pset_valid | input | 1 | A predicate-producing operation issued |
| pset_idx | input | 6 | Flag index that becomes pending |
| pwr_valid | input | 2 | Per write port: predicate write valid |
| pwr_idx | input | 12 | Per write port flag index (port p in bits 6p+5..6p) |
| pwr_value | input | 2 | Per write port value written |
| res_valid | input | 1 | Result offered by a functional unit |
| res_ready | output | 1 | Result accepted this cycle (low when buffer full) |
| res_pred | input | 6 | Flag index of the result (0 = unconditional) |
| res_dest | input | 7 | Destination register of the result |
| res_data | input | 32 | Result value |
| wb_valid | output | 1 | Committed writeback valid |
| wb_dest | output | 7 | Committed destination register |
| wb_data | output | 32 | Committed value |
| disc_valid | output | 1 | A result was discarded |
| disc_dest | output | 7 | Destination of the discarded result |

## Verification
The bench targets the cases where the predicate and the result interact in time. A result meets its flag's write in the same cycle; a design that used the stale value would discard what should commit. A known-true result queues behind a parked one; a design that bypassed the buffer would write back out of order. Further cases are a full buffer refusing a fifth result, and two write ports, or an issue and a write, hitting one flag together. A design with the wrong priority there would commit under the wrong value or lose the pending state, and would release a parked result too early.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [1:0] {
    VD_WAIT   = 2'd0,
    VD_COMMIT = 2'd1,
    VD_DROP   = 2'd2
  } verdict_e;

  // Outcome of a result given the resolved view of its flag.
  function automatic verdict_e judge(input logic pend, input logic val);
    if (pend)     return VD_WAIT;
    else if (val) return VD_COMMIT;
    else          return VD_DROP;
  endfunction

  // Next pending state: a fresh issue keeps the flag pending even
  // when an older producer writes it in the same cycle.
  function automatic logic next_pend(input logic cur, input logic issue,
                                     input logic written);
    if (issue)        return 1'b1;
    else if (written) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/pcg_pred_file.sv
module pcg_pred_file #(
  parameter int NUM_PRED = 64,
  parameter int NUM_WP   = 2,
  localparam int IW      = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IW-1:0]     set_idx,
  input  logic [NUM_WP-1:0] wr_en,
  input  logic [NUM_WP*IW-1:0] wr_idx,
  input  logic [NUM_WP-1:0] wr_val,
  input  logic [IW-1:0]     qa_idx,
  output logic              qa_pend,
  output logic              qa_val,
  input  logic [IW-1:0]     qb_idx,
  output logic              qb_pend,
  output logic              qb_val
);
  import pcg_pkg::*;

  // Resolved view: stored state overlaid by this cycle's writes.
  logic [NUM_PRED-1:0] eff_pend;
  logic [NUM_PRED-1:0] eff_val;

  for (genvar i = 0; i < NUM_PRED; i++) begin : g_flag
    if (i == 0) begin : g_const
      assign eff_pend[i] = 1'b0;
      assign eff_val[i]  = 1'b1;
    end else begin : g_store
      logic pend_q, val_q;
      logic hit, hit_val, issue_hit;

      always_comb begin
        hit     = 1'b0;
        hit_val = val_q;
        for (int p = 0; p < NUM_WP; p++) begin
          if (wr_en[p] && (wr_idx[p*IW +: IW] == IW'(i))) begin
            hit     = 1'b1;
            hit_val = wr_val[p];
          end
        end
      end

      assign issue_hit   = set_en && (set_idx == IW'(i));
      assign eff_pend[i] = hit ? 1'b0 : pend_q;
      assign eff_val[i]  = hit_val;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          val_q  <= 1'b0;
        end else begin
          pend_q <= next_pend(pend_q, issue_hit, hit);
          val_q  <= hit_val;
        end
      end
    end
  end

  assign qa_pend = eff_pend[qa_idx];
  assign qa_val  = eff_val[qa_idx];
  assign qb_pend = eff_pend[qb_idx];
  assign qb_val  = eff_val[qb_idx];

endmodule

// File: rtl/pcg_park_fifo.sv
module pcg_park_fifo #(
  parameter int WIDTH = 45,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_ent,
  input  logic             pop,
  output logic [WIDTH-1:0] head_ent,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign head_ent = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/pcg_out_stage.sv
module pcg_out_stage #(
  parameter int REG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              commit,
  input  logic [REG_W-1:0]  dest,
  input  logic [DATA_W-1:0] data,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_dest,
  output logic [DATA_W-1:0] wb_data,
  output logic              disc_valid,
  output logic [REG_W-1:0]  disc_dest
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_dest    <= '0;
      wb_data    <= '0;
      disc_valid <= 1'b0;
      disc_dest  <= '0;
    end else begin
      wb_valid   <= fire && commit;
      disc_valid <= fire && !commit;
      if (fire && commit) begin
        wb_dest <= dest;
        wb_data <= data;
      end
      if (fire && !commit) disc_dest <= dest;
    end
  end
endmodule

// File: rtl/pred_commit_gate.sv
module pred_commit_gate #(
  parameter int NUM_PRED = 64,
  parameter int NUM_WP   = 2,
  parameter int REG_W    = 7,
  parameter int DATA_W   = 32,
  parameter int PARK_D   = 4,
  localparam int IW      = $clog2(NUM_PRED),
  localparam int ENT_W   = IW + REG_W + DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pset_valid,
  input  logic [IW-1:0]        pset_idx,
  input  logic [NUM_WP-1:0]    pwr_valid,
  input  logic [NUM_WP*IW-1:0] pwr_idx,
  input  logic [NUM_WP-1:0]    pwr_value,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic [IW-1:0]        res_pred,
  input  logic [REG_W-1:0]     res_dest,
  input  logic [DATA_W-1:0]    res_data,
  output logic                 wb_valid,
  output logic [REG_W-1:0]     wb_dest,
  output logic [DATA_W-1:0]    wb_data,
  output logic                 disc_valid,
  output logic [REG_W-1:0]     disc_dest
);
  import pcg_pkg::*;

  // Named internal events, also watched by the checker.
  logic              in_pend, in_val, hd_pend, hd_val;
  logic              fifo_empty, fifo_full;
  logic [ENT_W-1:0]  head_ent, in_ent;
  logic [IW-1:0]     head_pred;
  logic [REG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_data;
  verdict_e          in_vd, hd_vd;
  logic              head_wait, head_take, direct_take, accept, push;
  logic              dec_fire, dec_commit;
  logic [IW-1:0]     dec_pred;
  logic [REG_W-1:0]  dec_dest;
  logic [DATA_W-1:0] dec_data;

  assign in_ent = {res_pred, res_dest, res_data};
  assign {head_pred, head_dest, head_data} = head_ent;

  pcg_pred_file #(.NUM_PRED(NUM_PRED), .NUM_WP(NUM_WP)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(pset_valid), .set_idx(pset_idx),
    .wr_en(pwr_valid), .wr_idx(pwr_idx), .wr_val(pwr_value),
    .qa_idx(res_pred), .qa_pend(in_pend), .qa_val(in_val),
    .qb_idx(head_pred), .qb_pend(hd_pend), .qb_val(hd_val)
  );

  assign in_vd = judge(in_pend, in_val);
  assign hd_vd = judge(hd_pend, hd_val);

  assign res_ready   = !fifo_full;
  assign accept      = res_valid && res_ready;
  assign head_wait   = !fifo_empty && (hd_vd == VD_WAIT);
  assign head_take   = !fifo_empty && (hd_vd != VD_WAIT);
  // Only bypass the buffer when nothing older is parked.
  assign direct_take = accept && fifo_empty && (in_vd != VD_WAIT);
  assign push        = accept && !direct_take;

  always_comb begin
    dec_fire   = 1'b0;
    dec_commit = 1'b0;
    dec_pred   = head_pred;
    dec_dest   = head_dest;
    dec_data   = head_data;
    if (head_take) begin
      dec_fire   = 1'b1;
      dec_commit = (hd_vd == VD_COMMIT);
    end else if (direct_take) begin
      dec_fire   = 1'b1;
      dec_commit = (in_vd == VD_COMMIT);
      dec_pred   = res_pred;
      dec_dest   = res_dest;
      dec_data   = res_data;
    end
  end

  pcg_park_fifo #(.WIDTH(ENT_W), .DEPTH(PARK_D)) u_park (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ent(in_ent), .pop(head_take),
    .head_ent(head_ent), .empty(fifo_empty), .full(fifo_full)
  );

  pcg_out_stage #(.REG_W(REG_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .fire(dec_fire), .commit(dec_commit), .dest(dec_dest), .data(dec_data),
    .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data),
    .disc_valid(disc_valid), .disc_dest(disc_dest)
  );

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int IW    = 6,
  parameter int ENT_W = 45
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_valid,
  input logic             disc_valid,
  input logic             dec_fire,
  input logic             dec_commit,
  input logic [IW-1:0]    dec_pred,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             push,
  input logic             head_wait,
  input logic             direct_take,
  input logic [ENT_W-1:0] head_ent
);
  // R4: never both outcomes at once
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && disc_valid));

  // R2: flag 0 decisions always commit
  p_flag0_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && dec_pred == '0) |-> dec_commit);

  // R9: nothing enters a full buffer
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);

  // R5: a waiting head stays in place
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    head_wait |=> (!fifo_empty && $stable(head_ent)));

  // R8: no bypass while older results are parked
  p_in_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |-> !direct_take);

  // R3: an outcome follows a decision by one cycle
  p_out_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || disc_valid) |-> $past(dec_fire));
endmodule

bind pred_commit_gate pcg_checker #(.IW(IW), .ENT_W(ENT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .disc_valid(disc_valid),
  .dec_fire(dec_fire), .dec_commit(dec_commit), .dec_pred(dec_pred),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .push(push),
  .head_wait(head_wait), .direct_take(direct_take), .head_ent(head_ent)
);

// File: tb/pred_commit_gate_test.sv
module pred_commit_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pset_valid;
  logic [5:0]  pset_idx;
  logic [1:0]  pwr_valid;
  logic [11:0] pwr_idx;
  logic [1:0]  pwr_value;
  logic        res_valid, res_ready;
  logic [5:0]  res_pred;
  logic [6:0]  res_dest;
  logic [31:0] res_data;
  logic        wb_valid, disc_valid;
  logic [6:0]  wb_dest, disc_dest;
  logic [31:0] wb_data;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pred_commit_gate uut (
    .clk(clk), .rst_n(rst_n), .pset_valid(pset_valid), .pset_idx(pset_idx),
    .pwr_valid(pwr_valid), .pwr_idx(pwr_idx), .pwr_value(pwr_value),
    .res_valid(res_valid), .res_ready(res_ready), .res_pred(res_pred),
    .res_dest(res_dest), .res_data(res_data), .wb_valid(wb_valid),
    .wb_dest(wb_dest), .wb_data(wb_data), .disc_valid(disc_valid),
    .disc_dest(disc_dest)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    pset_valid = 0; pset_idx = 0; pwr_valid = 0; pwr_idx = 0; pwr_value = 0;
    res_valid = 0; res_pred = 0; res_dest = 0; res_data = 0;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outcome kinds: 0 none, 1 writeback, 2 discard
  task automatic expect_out(input string tag, input int kind,
                            input logic [6:0] dest, input logic [31:0] data);
    logic [63:0] act, exp;
    act = {22'd0, wb_valid, disc_valid, 8'd0, 32'd0};
    exp = {22'd0, kind == 1, kind == 2, 8'd0, 32'd0};
    if (wb_valid)   act[39:0] = {1'b0, wb_dest, wb_data};
    if (disc_valid) act[39:0] = {1'b0, disc_dest, 32'd0};
    if (kind == 1)  exp[39:0] = {1'b0, dest, data};
    if (kind == 2)  exp[39:0] = {1'b0, dest, 32'd0};
    check(tag, act, exp);
  endtask

  task automatic issue(input logic [5:0] i);
    pset_valid = 1; pset_idx = i;
  endtask
  task automatic pwrite(input int port, input logic [5:0] i, input logic v);
    pwr_valid[port] = 1; pwr_idx[port*6 +: 6] = i; pwr_value[port] = v;
  endtask
  task automatic result(input logic [5:0] p, input logic [6:0] d, input logic [31:0] x);
    res_valid = 1; res_pred = p; res_dest = d; res_data = x;
  endtask

  task automatic t_reset();
    check("R1 ready after reset", {63'd0, res_ready}, 64'd1);
    expect_out("R1 no outcome after reset", 0, 0, 0);
    result(5, 5, 32'hAA); tick(); idle();
    expect_out("R1 flag5 resets to 0", 2, 5, 0);
  endtask

  task automatic t_flag0();
    pwrite(0, 0, 0); tick(); idle();
    issue(0); tick(); idle();
    result(0, 1, 32'h11); tick(); idle();
    expect_out("R2 flag0 commits", 1, 1, 32'h11);
  endtask

  task automatic t_known();
    pwrite(0, 10, 1); tick(); idle();
    result(10, 2, 32'h22); tick(); idle();
    expect_out("R3 known true commits", 1, 2, 32'h22);
    tick();
    expect_out("R3 single cycle", 0, 0, 0);
    pwrite(1, 11, 0); tick(); idle();
    result(11, 3, 32'h33); tick(); idle();
    expect_out("R4 known false discards", 2, 3, 0);
  endtask

  task automatic t_pending();
    issue(20); tick(); idle();
    result(20, 4, 32'h44); tick(); idle();
    expect_out("R5 parked no output", 0, 0, 0);
    tick();
    expect_out("R5 still parked", 0, 0, 0);
    pwrite(0, 20, 1); tick(); idle();
    expect_out("R6 resolve true commits", 1, 4, 32'h44);
    issue(21); tick(); idle();
    result(21, 5, 32'h55); tick(); idle();
    pwrite(1, 21, 0); tick(); idle();
    expect_out("R6 resolve false discards", 2, 5, 0);
  endtask

  task automatic t_same_cycle();
    issue(30); tick(); idle();
    pwrite(0, 30, 1); result(30, 6, 32'h66); tick(); idle();
    expect_out("R7 same-cycle write 1", 1, 6, 32'h66);
    pwrite(0, 31, 1); tick(); idle();
    issue(31); tick(); idle();
    pwrite(0, 31, 0); result(31, 7, 32'h67); tick(); idle();
    expect_out("R7 same-cycle write 0", 2, 7, 0);
  endtask

  task automatic t_order();
    issue(40); tick(); idle();
    result(40, 8, 32'h77); tick(); idle();
    result(0, 9, 32'h88); tick(); idle();
    expect_out("R8 known waits behind parked", 0, 0, 0);
    pwrite(0, 40, 0); tick(); idle();
    expect_out("R8 older leaves first", 2, 8, 0);
    tick();
    expect_out("R8 younger next", 1, 9, 32'h88);
  endtask

  task automatic t_full();
    issue(50); tick(); idle();
    for (int k = 0; k < 4; k++) begin
      result(50, 7'(10 + k), 32'(256 + k)); tick(); idle();
    end
    check("R9 ready low when full", {63'd0, res_ready}, 64'd0);
    result(0, 14, 32'hDEAD); tick(); idle();
    expect_out("R9 refused no output", 0, 0, 0);
    pwrite(1, 50, 1); tick(); idle();
    for (int k = 0; k < 4; k++) begin
      expect_out("R9 drain order", 1, 7'(10 + k), 32'(256 + k));
      tick();
    end
    expect_out("R9 refused result never appears", 0, 0, 0);
    check("R9 ready back", {63'd0, res_ready}, 64'd1);
  endtask

  task automatic t_both_paths();
    issue(60); tick(); idle();
    issue(61); tick(); idle();
    result(60, 20, 32'hA0); tick(); idle();
    result(61, 21, 32'hB0); tick(); idle();
    pwrite(0, 60, 1); pwrite(1, 61, 0); tick(); idle();
    expect_out("R10 true arm commits", 1, 20, 32'hA0);
    tick();
    expect_out("R10 false arm discards", 2, 21, 0);
  endtask

  task automatic t_priority();
    pwrite(0, 12, 0); pwrite(1, 12, 1); tick(); idle();
    result(12, 22, 32'hC0); tick(); idle();
    expect_out("R11 port1 wins", 1, 22, 32'hC0);
    issue(13); pwrite(0, 13, 1); tick(); idle();
    result(13, 23, 32'hC1); tick(); idle();
    expect_out("R11 issue keeps pending", 0, 0, 0);
    pwrite(0, 13, 0); tick(); idle();
    expect_out("R11 later write decides", 2, 23, 0);
  endtask

  initial begin
    fork
      begin
        idle(); rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset(); t_flag0(); t_known(); t_pending(); t_same_cycle();
        t_order(); t_full(); t_both_paths(); t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule